// File: doc/BRIEF.md
# Reference Clock Failover Controller

This block decides which of two redundant reference clocks, A or B, feeds a downstream PLL. A separate monitor supplies a presence flag for each reference. The controller either follows a manual choice or fails over automatically. Automatic failover can be revertive or nonrevertive. When both references are gone, the controller freezes its selection and enters holdover. In holdover it tells the charge pump to float or to sit at mid-supply.

The manual choice comes from a software bit or from an external pin. A configuration input picks between the two. The pin is asynchronous and passes through a two-flop synchronizer. Every change of the selected reference produces a one-cycle pulse, so the PLL can start resynchronizing.

Top module: `refsel_ctrl`

## Requirements
- R1: While rst_n is low and after its release, sel_b is 0 (reference A), holdover is 0, switch_pulse is 0 and cp_ctrl is 2'b00 (normal).
- R2: With auto_en=0 and man_src_pin=0, sel_b takes the value of man_sel_reg one clock edge after it is sampled. sel_b=1 means reference B. The pin has no effect.
- R3: With auto_en=0 and man_src_pin=1, sel_b follows man_sel_pin three clock edges after the pin changes (two synchronizer stages plus the select register). man_sel_reg has no effect.
- R4: With auto_en=1, when A is selected, not in holdover, ref_a_ok=0 and ref_b_ok=1, sel_b becomes 1 on the next edge.
- R5: With auto_en=1 and revert_en=0, while B is selected and ref_b_ok=1, sel_b stays 1 whatever ref_a_ok does.
- R6: With auto_en=1, while B is selected, ref_b_ok=0 and ref_a_ok=1, sel_b returns to 0 on the next edge.
- R7: With auto_en=1 and revert_en=1, while B is selected, ref_a_ok=1 returns sel_b to 0 on the next edge.
- R8: When both ref_a_ok and ref_b_ok are 0, holdover is 1 from the next edge. In automatic mode sel_b keeps its value.
- R9: In automatic mode, the first edge that samples either reference present while in holdover clears holdover. That edge selects A if ref_a_ok=1, otherwise B, so A wins a tie.
- R10: cp_ctrl is 2'b00 outside holdover. In holdover it is 2'b01 (tristate) when hold_midrail=0 and 2'b10 (mid-supply) when hold_midrail=1. It follows hold_midrail without a clock edge.
- R11: switch_pulse is 1 for exactly the cycle in which sel_b differs from its value in the cycle before, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_ok | input | 1 | Reference A present (synchronous) |
| ref_b_ok | input | 1 | Reference B present (synchronous) |
| auto_en | input | 1 | 1 = automatic failover, 0 = manual |
| revert_en | input | 1 | 1 = revertive, 0 = nonrevertive |
| man_src_pin | input | 1 | Manual source: 1 = pin, 0 = register bit |
| man_sel_reg | input | 1 | Manual select bit, 1 = B |
| man_sel_pin | input | 1 | Asynchronous manual select pin, 1 = B |
| hold_midrail | input | 1 | Drive the charge pump to mid-supply in holdover |
| sel_b | output | 1 | Active reference, 1 = B |
| holdover | output | 1 | Holdover state |
| cp_ctrl | output | 2 | Charge-pump control: 00 normal, 01 tristate, 10 mid-supply |
| switch_pulse | output | 1 | One-cycle pulse on each change of reference |

## Verification
The presence flags, the mode bits and the register select reach sel_b, holdover and switch_pulse on the first rising edge that samples them. The pin reaches them on the third edge. cp_ctrl follows holdover and hold_midrail with no edge at all. The bench drives every input on the falling edge. Its behavioural model advances on each rising edge, and a queue of the two most recent pin values stands for the synchronizer delay. All four outputs are compared one nanosecond after each rising edge, so every result is checked in the cycle it becomes due.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
  typedef enum logic [1:0] {
    CP_NORMAL   = 2'b00,
    CP_TRISTATE = 2'b01,
    CP_MIDRAIL  = 2'b10
  } cp_mode_e;
endpackage

// File: rtl/refsel_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous level input.
module refsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/refsel_sel_fsm.sv
`timescale 1ns/1ps
// Selection and holdover state with next-state / register split.
module refsel_sel_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic a_ok,
  input  logic b_ok,
  input  logic auto_en,
  input  logic revert_en,
  input  logic man_sel,
  output logic sel_b_q,
  output logic hold_q,
  output logic pulse_q
);
  logic sel_b_n;
  logic hold_n;
  logic state_en;
  logic none_ok;

  assign none_ok = !a_ok && !b_ok;

  always_comb begin
    sel_b_n = sel_b_q;
    hold_n  = hold_q;
    if (!auto_en) begin
      sel_b_n = man_sel;
      hold_n  = none_ok;
    end else if (none_ok) begin
      hold_n  = 1'b1;
    end else if (hold_q) begin
      hold_n  = 1'b0;
      sel_b_n = !a_ok;            // A preferred when both return
    end else if (!sel_b_q) begin
      if (!a_ok) sel_b_n = 1'b1;  // B is present here
    end else begin
      if (!b_ok || (revert_en && a_ok)) sel_b_n = 1'b0;
    end
  end

  assign state_en = (sel_b_n != sel_b_q) || (hold_n != hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_b_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (state_en) begin
      sel_b_q <= sel_b_n;
      hold_q  <= hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= (sel_b_n != sel_b_q);
  end
endmodule

// File: rtl/refsel_cp_enc.sv
`timescale 1ns/1ps
// Charge-pump control encoding from holdover state.
module refsel_cp_enc
  import refsel_pkg::*;
(
  input  logic       hold,
  input  logic       midrail,
  output logic [1:0] cp
);
  cp_mode_e mode;

  always_comb begin
    if (!hold)        mode = CP_NORMAL;
    else if (midrail) mode = CP_MIDRAIL;
    else              mode = CP_TRISTATE;
  end

  assign cp = mode;
endmodule

// File: rtl/refsel_ctrl.sv
`timescale 1ns/1ps
module refsel_ctrl #(
  parameter int PIN_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_a_ok,
  input  logic       ref_b_ok,
  input  logic       auto_en,
  input  logic       revert_en,
  input  logic       man_src_pin,
  input  logic       man_sel_reg,
  input  logic       man_sel_pin,
  input  logic       hold_midrail,
  output logic       sel_b,
  output logic       holdover,
  output logic [1:0] cp_ctrl,
  output logic       switch_pulse
);
  logic pin_sync;
  logic man_sel;

  refsel_sync #(.STAGES(PIN_SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (man_sel_pin),
    .q     (pin_sync)
  );

  assign man_sel = man_src_pin ? pin_sync : man_sel_reg;

  refsel_sel_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_ok      (ref_a_ok),
    .b_ok      (ref_b_ok),
    .auto_en   (auto_en),
    .revert_en (revert_en),
    .man_sel   (man_sel),
    .sel_b_q   (sel_b),
    .hold_q    (holdover),
    .pulse_q   (switch_pulse)
  );

  refsel_cp_enc u_cp (
    .hold    (holdover),
    .midrail (hold_midrail),
    .cp      (cp_ctrl)
  );
endmodule

// File: rtl/refsel_ctrl_chk.sv
`timescale 1ns/1ps
module refsel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_a_ok,
  input logic       ref_b_ok,
  input logic       auto_en,
  input logic       revert_en,
  input logic       sel_b,
  input logic       holdover,
  input logic [1:0] cp_ctrl,
  input logic       switch_pulse
);
  a_r4_failover_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !sel_b && !holdover && !ref_a_ok && ref_b_ok) |=> sel_b);

  a_r5_nonrevert_stays_b: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !revert_en && sel_b && ref_b_ok && !holdover) |=> sel_b);

  a_r7_revert_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && revert_en && sel_b && ref_a_ok && !holdover) |=> !sel_b);

  a_r8_hold_needs_loss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover) |-> $past(!ref_a_ok && !ref_b_ok));

  a_r9_exit_prefers_a: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && holdover && ref_a_ok) |=> (!sel_b && !holdover));

  a_r10_cp_active_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |-> (cp_ctrl == 2'b01 || cp_ctrl == 2'b10));

  a_r10_cp_normal_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !holdover |-> (cp_ctrl == 2'b00));

  a_r11_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b != $past(sel_b)) |-> switch_pulse);

  a_r11_pulse_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (sel_b != $past(sel_b)));
endmodule

bind refsel_ctrl refsel_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_a_ok     (ref_a_ok),
  .ref_b_ok     (ref_b_ok),
  .auto_en      (auto_en),
  .revert_en    (revert_en),
  .sel_b        (sel_b),
  .holdover     (holdover),
  .cp_ctrl      (cp_ctrl),
  .switch_pulse (switch_pulse)
);

// File: tb/refsel_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsel_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       ref_a_ok, ref_b_ok, auto_en, revert_en;
  logic       man_src_pin, man_sel_reg, man_sel_pin, hold_midrail;
  logic       sel_b, holdover, switch_pulse;
  logic [1:0] cp_ctrl;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // behavioural model state
  int m_sel, m_hold, m_pulse, m_prev, m_psync, m_man, m_cp;
  int pinq[$];

  refsel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ref_a_ok(ref_a_ok), .ref_b_ok(ref_b_ok),
    .auto_en(auto_en), .revert_en(revert_en), .man_src_pin(man_src_pin),
    .man_sel_reg(man_sel_reg), .man_sel_pin(man_sel_pin),
    .hold_midrail(hold_midrail), .sel_b(sel_b), .holdover(holdover),
    .cp_ctrl(cp_ctrl), .switch_pulse(switch_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    m_cp = (m_hold == 0) ? 0 : (hold_midrail ? 2 : 1);
    check(cur_req, "sel_b",    int'(sel_b),        m_sel);
    check(cur_req, "holdover", int'(holdover),     m_hold);
    check("R10",   "cp_ctrl",  int'(cp_ctrl),      m_cp);
    check("R11",   "switch_pulse", int'(switch_pulse), m_pulse);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      m_psync = pinq[0];
      void'(pinq.pop_front());
      pinq.push_back(int'(man_sel_pin));
      m_man  = man_src_pin ? m_psync : int'(man_sel_reg);
      m_prev = m_sel;
      if (!auto_en) begin
        m_sel  = m_man;
        m_hold = (!ref_a_ok && !ref_b_ok) ? 1 : 0;
      end else if (!ref_a_ok && !ref_b_ok) begin
        m_hold = 1;
      end else if (m_hold == 1) begin
        m_hold = 0;
        m_sel  = ref_a_ok ? 0 : 1;
      end else if (m_sel == 0) begin
        if (!ref_a_ok) m_sel = 1;
      end else begin
        if (!ref_b_ok || (revert_en && ref_a_ok)) m_sel = 0;
      end
      m_pulse = (m_sel != m_prev) ? 1 : 0;
      #1 compare_all();
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_refs(bit a, bit b);
    @(negedge clk);
    ref_a_ok = a;
    ref_b_ok = b;
  endtask

  initial begin
    rst_n = 1'b0;
    ref_a_ok = 1; ref_b_ok = 1; auto_en = 0; revert_en = 0;
    man_src_pin = 0; man_sel_reg = 1; man_sel_pin = 1; hold_midrail = 0;
    m_sel = 0; m_hold = 0; m_pulse = 0;
    pinq = '{0, 0};
    #7;
    // R1: reset state while held in reset
    check("R1", "sel_b in reset",    int'(sel_b), 0);
    check("R1", "holdover in reset", int'(holdover), 0);
    check("R1", "cp_ctrl in reset",  int'(cp_ctrl), 0);
    check("R1", "pulse in reset",    int'(switch_pulse), 0);
    @(negedge clk);
    man_sel_reg = 0;
    rst_n = 1'b1;
    run(3);

    // R2: manual register select, pin ignored
    cur_req = "R2";
    @(negedge clk); man_sel_reg = 1; man_sel_pin = 0;
    run(3);
    @(negedge clk); man_sel_reg = 0; man_sel_pin = 1;
    run(3);
    @(negedge clk); man_sel_reg = 1;
    run(2);

    // R3: manual pin select through synchronizer, register ignored
    cur_req = "R3";
    @(negedge clk); man_src_pin = 1; man_sel_pin = 0; man_sel_reg = 1;
    run(5);
    @(negedge clk); man_sel_pin = 1; man_sel_reg = 0;
    run(5);
    @(negedge clk); man_sel_pin = 0;
    @(negedge clk); man_sel_pin = 1;
    @(negedge clk); man_sel_pin = 0;
    run(5);

    // R4: automatic failover, nonrevertive
    cur_req = "R4";
    @(negedge clk); auto_en = 1; revert_en = 0; man_src_pin = 0;
    run(3);
    set_refs(0, 1);
    run(3);

    // R5: A returns, stay on B
    cur_req = "R5";
    set_refs(1, 1);
    run(6);

    // R6: B lost, back to A
    cur_req = "R6";
    set_refs(1, 0);
    run(3);
    set_refs(1, 1);
    run(2);

    // R7: revertive
    cur_req = "R7";
    @(negedge clk); revert_en = 1;
    set_refs(0, 1);
    run(3);
    set_refs(1, 1);
    run(3);

    // R8: holdover while on B keeps B; cp encodings (R10)
    cur_req = "R8";
    @(negedge clk); revert_en = 0;
    set_refs(0, 1);
    run(2);
    set_refs(0, 0);
    run(3);
    @(negedge clk); hold_midrail = 1;
    run(3);
    @(negedge clk); hold_midrail = 0;
    run(2);

    // R9: exit holdover with only B, then tie prefers A
    cur_req = "R9";
    set_refs(0, 1);
    run(3);
    set_refs(0, 0);
    run(3);
    set_refs(1, 1);
    run(3);
    set_refs(0, 0);
    run(2);
    set_refs(1, 0);
    run(3);

    // R8: holdover in manual mode
    cur_req = "R8";
    @(negedge clk); auto_en = 0; man_sel_reg = 1;
    set_refs(0, 0);
    run(3);
    set_refs(1, 1);
    run(2);

    // mixed random traffic, all rules together
    cur_req = "R4";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ref_a_ok     = $urandom_range(0, 3) != 0;
      ref_b_ok     = $urandom_range(0, 3) != 0;
      revert_en    = $urandom_range(0, 1) == 1;
      hold_midrail = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) auto_en = ~auto_en;
      man_src_pin  = $urandom_range(0, 1) == 1;
      man_sel_reg  = $urandom_range(0, 1) == 1;
      man_sel_pin  = $urandom_range(0, 1) == 1;
    end
    run(4);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule